// File: doc/BRIEF.md
# Cycle-Stealing Block DMA Engine

This block moves a block of words out of a device controller's local buffer and writes them into main memory. It does this over one memory bus that it shares with a CPU port. Software starts a block by presenting a destination base address and a word count. From then on the engine takes each valid word that the buffer offers and writes it to consecutive memory addresses. The CPU is not involved in any single word.

A fixed-priority arbiter sits in front of the memory bus. In any cycle where the buffer offers a word during a transfer, the engine owns the bus. If the CPU asks for the bus in that same cycle, its access is held off by a stall and must be presented again. The CPU therefore loses that one cycle but not the access itself. In every other cycle the CPU has the bus to itself, so CPU work and the transfer overlap freely. When the last word has been written, a single level interrupt goes high. It stays high until it is cleared, and no new block can start while it is high.

Top module: `blk_dma_steal`

## Requirements
- R1: While reset is held low, and on the first cycle after it, `busy`, `irq`, `buf_ready` and `cpu_stall` are all 0.
- R2: A start is accepted when `start` is 1, the engine is idle, `irq` is 0 and `start_len` is nonzero. `busy` goes high on the next cycle. From then on, each cycle with `buf_valid` high writes `buf_data` to memory (`mem_en`=1, `mem_we`=1, `buf_ready`=1). The writes go to the base address, then base+1, base+2 and so on, in order.
- R3: In a cycle with `busy`, `buf_valid` and `cpu_req` all high, the engine's write is on the memory bus and `cpu_stall` is 1.
- R4: While `buf_valid` is 0, the engine does not use the bus and `buf_ready` is 0, even during a transfer.
- R5: In a cycle the engine does not use the bus, the memory bus carries the CPU's enable, write flag, address and write data unchanged, and `cpu_stall` is 0. If neither side asks for the bus, `mem_en` is 0.
- R6: `irq` goes high, and `busy` goes low, on the cycle after the write of the block's last word. Exactly one such rise happens per block, including a block of one word.
- R7: `irq` stays high until `irq_clr` is 1 for a cycle. It is 0 from the next cycle on.
- R8: A start during a transfer is ignored. The block still writes exactly its original count of words, and its addresses keep incrementing from where they were.
- R9: A start while `irq` is high is ignored, even in the same cycle as `irq_clr`. `busy` stays 0.
- R10: A start with `start_len` equal to 0 is ignored, and `busy` stays 0.
- R11: A CPU access that was stalled and held unchanged is put on the bus, with `cpu_stall` at 0, in the first cycle where the engine does not request the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start command for one block |
| start_addr | input | ADDR_W | Destination base word address |
| start_len | input | CNT_W | Number of words in the block |
| irq_clr | input | 1 | One-cycle clear of the completion interrupt |
| buf_valid | input | 1 | Device buffer offers a word |
| buf_data | input | DATA_W | Word offered by the device buffer |
| buf_ready | output | 1 | Offered word is written this cycle |
| cpu_req | input | 1 | CPU asks for the memory bus |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | Read data from memory passed to the CPU |
| cpu_stall | output | 1 | CPU access lost arbitration this cycle |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| busy | output | 1 | A block transfer is in progress |
| irq | output | 1 | Block-complete interrupt level |

## Verification
The bench drives CPU requests and buffer-valid gaps in the same cycles, so that contention, stalls and retries interleave with the transfer. A wrong arbiter would show up as the CPU winning, or as a stall raised when there was no contention. A block of one word and a block whose last word arrives during a CPU request both test the end of the count. Getting the count end wrong raises the interrupt early or late, or writes a word too many. Starts are sent during a transfer, while the interrupt is pending, in the same cycle as the clear, and with a zero count. A design that accepted any of these would reload its address or count, and would show up as a changed write sequence or an unexpected high on `busy`.

// File: rtl/dma_steal_pkg.sv
// Package: shared types for the cycle-stealing DMA engine.
// Assumes nothing beyond a single shared memory bus with two masters.
package dma_steal_pkg;

    // Owner of the memory bus in the current cycle
    typedef enum logic [1:0] {
        OWNER_IDLE = 2'd0,
        OWNER_CPU  = 2'd1,
        OWNER_DMA  = 2'd2
    } bus_owner_e;

endpackage

// File: rtl/steal_arbiter.sv
// Module: steal_arbiter
// Fixed-priority arbiter for the shared memory bus. A DMA request always
// wins. A CPU request that meets a DMA request in the same cycle is stalled.
// Assumes: requests are single-cycle accesses, decided combinationally.
module steal_arbiter
    import dma_steal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dma_req,
    input  logic       cpu_req,
    output logic       gnt_dma,
    output logic       gnt_cpu,
    output logic       cpu_stall,
    output bus_owner_e owner
);

    // Priority decision: DMA first, then CPU
    always_comb begin
        gnt_dma   = dma_req;
        gnt_cpu   = cpu_req & ~dma_req;
        cpu_stall = cpu_req & dma_req;
        if (dma_req)
            owner = OWNER_DMA;
        else if (cpu_req)
            owner = OWNER_CPU;
        else
            owner = OWNER_IDLE;
    end

    // R3
    grant_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_dma, gnt_cpu}));

    // R3
    dma_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && cpu_req) |-> (owner == OWNER_DMA && cpu_stall && !gnt_cpu));

    // R5
    no_idle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_req |-> !cpu_stall);

endmodule

// File: rtl/dma_channel.sv
// Module: dma_channel
// Holds the address and count registers for one block and the completion
// interrupt. It requests the bus whenever a transfer is in progress and the
// buffer offers a word. Each granted write steps the address up by one
// and the count down by one.
// Assumes: grant is returned in the same cycle as the request.
module dma_channel #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_len,
    input  logic              irq_clr,
    input  logic              buf_valid,
    input  logic              grant,
    output logic              dma_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              busy,
    output logic              irq
);

    localparam logic [CNT_W-1:0]  LAST_WORD = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q;
    logic              irq_q;
    logic              start_ok;
    logic              last_beat;

    // Start acceptance and last-word detection
    always_comb begin
        start_ok  = start && !busy_q && !irq_q && (start_len != '0);
        last_beat = busy_q && grant && (cnt_q == LAST_WORD);
        dma_req   = busy_q && buf_valid;
    end

    // Address, count, busy and interrupt registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            irq_q  <= 1'b0;
        end else if (busy_q) begin
            if (grant) begin
                addr_q <= addr_q + ADDR_STEP;
                cnt_q  <= cnt_q - LAST_WORD;
            end
            if (last_beat) begin
                busy_q <= 1'b0;
                irq_q  <= 1'b1;
            end
        end else begin
            if (start_ok) begin
                addr_q <= start_addr;
                cnt_q  <= start_len;
                busy_q <= 1'b1;
            end
            if (irq_clr)
                irq_q <= 1'b0;
        end
    end

    assign wr_addr = addr_q;
    assign busy    = busy_q;
    assign irq     = irq_q;

    // R2
    step_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && grant && cnt_q != LAST_WORD) |=>
            (busy_q && cnt_q == $past(cnt_q) - LAST_WORD && addr_q == $past(addr_q) + ADDR_STEP));

    // R8
    hold_without_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !grant) |=> ($stable(cnt_q) && $stable(addr_q) && busy_q));

    // R6
    irq_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> (irq_q && !busy_q));

    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr) |=> irq_q);

    // R9
    no_start_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !busy_q) |=> !busy_q);

    // R6
    irq_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_q && busy_q));

endmodule

// File: rtl/bus_mux.sv
// Module: bus_mux
// Steers the shared memory bus to the owner chosen by the arbiter. DMA
// accesses are always writes. The bus is disabled when no one owns it.
// Assumes: owner is one of the three enumerated values.
module bus_mux
    import dma_steal_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  bus_owner_e        owner,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_data,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    // Select the bus fields of the current owner
    always_comb begin
        case (owner)
            OWNER_DMA: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dma_addr;
                mem_wdata = dma_data;
            end
            OWNER_CPU: begin
                mem_en    = 1'b1;
                mem_we    = cpu_we;
                mem_addr  = cpu_addr;
                mem_wdata = cpu_wdata;
            end
            default: begin
                mem_en    = 1'b0;
                mem_we    = 1'b0;
                mem_addr  = '0;
                mem_wdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/blk_dma_steal.sv
// Module: blk_dma_steal
// Block DMA engine that steals single memory-bus cycles from a CPU port. It
// joins the channel registers, the fixed-priority arbiter and the bus
// steering. Read data from memory goes straight back to the CPU.
// Assumes: memory accepts one access per cycle with no back-pressure.
module blk_dma_steal
    import dma_steal_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_len,
    input  logic              irq_clr,
    input  logic              buf_valid,
    input  logic [DATA_W-1:0] buf_data,
    output logic              buf_ready,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              irq
);

    logic              dma_req;
    logic              gnt_dma;
    logic              gnt_cpu;
    logic [ADDR_W-1:0] dma_addr;
    bus_owner_e        owner;

    dma_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_channel (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .start_len  (start_len),
        .irq_clr    (irq_clr),
        .buf_valid  (buf_valid),
        .grant      (gnt_dma),
        .dma_req    (dma_req),
        .wr_addr    (dma_addr),
        .busy       (busy),
        .irq        (irq)
    );

    steal_arbiter u_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_req   (dma_req),
        .cpu_req   (cpu_req),
        .gnt_dma   (gnt_dma),
        .gnt_cpu   (gnt_cpu),
        .cpu_stall (cpu_stall),
        .owner     (owner)
    );

    bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .owner     (owner),
        .dma_addr  (dma_addr),
        .dma_data  (buf_data),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // Handshake back to the buffer and read data back to the CPU
    assign buf_ready = gnt_dma;
    assign cpu_rdata = mem_rdata;

    // R4
    no_word_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_valid |-> !buf_ready);

    // R3
    stall_means_dma_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> (mem_en && mem_we && mem_wdata == buf_data));

    // R5
    cpu_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_cpu |-> (mem_en && mem_addr == cpu_addr && mem_we == cpu_we && !cpu_stall));

endmodule

// File: tb/test_blk_dma_steal.sv
`timescale 1ns/1ps
module test_blk_dma_steal;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] start_len = '0;
    logic          irq_clr = 1'b0;
    logic          buf_valid = 1'b0;
    logic [DW-1:0] buf_data = '0;
    logic          buf_ready;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_stall;
    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy;
    logic          irq;

    blk_dma_steal #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_blk_dma_steal (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_len(start_len), .irq_clr(irq_clr), .buf_valid(buf_valid),
        .buf_data(buf_data), .buf_ready(buf_ready), .cpu_req(cpu_req),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .irq(irq)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic          dma;
        logic          we;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } op_t;

    op_t     exp_q[$];
    int      n_checks = 0;
    int      n_fail = 0;
    int      blk_writes = 0;
    bit      mon_on = 1'b0;

    // reference state from the requirements
    logic          m_busy = 1'b0;
    logic          m_irq = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [CW-1:0] m_cnt = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, immediate checks and scoreboard push
    task automatic cyc(input bit v, input logic [DW-1:0] bd, input bit cr, input bit cw,
                       input logic [AW-1:0] ca, input logic [DW-1:0] cd,
                       input bit st, input logic [AW-1:0] sa, input logic [CW-1:0] sl,
                       input bit clr);
        bit dma;
        @(negedge clk);
        buf_valid = v; buf_data = bd; cpu_req = cr; cpu_we = cw; cpu_addr = ca;
        cpu_wdata = cd; start = st; start_addr = sa; start_len = sl; irq_clr = clr;
        #1;
        dma = m_busy && v;
        chk(busy == m_busy, "R2 busy", 64'(busy), 64'(m_busy));
        chk(irq == m_irq, "R6 irq", 64'(irq), 64'(m_irq));
        chk(buf_ready == dma, "R4 buf_ready", 64'(buf_ready), 64'(dma));
        chk(cpu_stall == (cr && dma), "R3 cpu_stall", 64'(cpu_stall), 64'(cr && dma));
        if (dma) begin
            exp_q.push_back({1'b1, 1'b1, m_addr, bd});
            blk_writes++;
            m_addr = m_addr + 1'b1;
            m_cnt  = m_cnt - 1'b1;
            if (m_cnt == '0) begin
                m_busy = 1'b0;
                m_irq  = 1'b1;
            end
        end else begin
            if (cr) exp_q.push_back({1'b0, cw, ca, cd});
            if (!m_busy) begin
                if (st && !m_irq && sl != '0) begin
                    m_busy = 1'b1; m_addr = sa; m_cnt = sl; blk_writes = 0;
                end
                if (clr) m_irq = 1'b0;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, '0, '0, 0, '0, '0, 0);
    endtask

    // monitor: compares each bus cycle with the next expected item
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mon_on && (mem_en || exp_q.size() > 0)) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R5 unexpected bus access", 64'(mem_addr), 64'(0));
                end else begin
                    op_t e;
                    e = exp_q.pop_front();
                    chk(mem_en && mem_we == e.we && mem_addr == e.a && (!e.we || mem_wdata == e.d),
                        e.dma ? "R2 dma write" : "R5 cpu access",
                        {mem_en, mem_we, 14'(mem_addr), mem_wdata[31:0]},
                        {1'b1, e.we, 14'(e.a), e.d[31:0]});
                end
            end
        end
    end

    // watchdog
    initial begin
        #1_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !irq && !buf_ready && !cpu_stall, "R1 reset outputs",
            {busy, irq, buf_ready, cpu_stall}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        mon_on = 1'b1;
        chk(!busy && !irq, "R1 after reset", {busy, irq}, 0);

        // R5 CPU alone on an idle bus
        cyc(0, '0, 1, 1, 16'h0100, 32'hAAAA_0001, 0, '0, '0, 0);
        chk(mem_addr == 16'h0100 && !cpu_stall, "R5 cpu write", 64'(mem_addr), 64'h100);
        cyc(0, '0, 1, 0, 16'h0104, 32'h0, 0, '0, '0, 0);
        cyc(1, 32'hDEAD_BEEF, 0, 0, '0, '0, 0, '0, '0, 0);
        chk(!mem_en && !buf_ready, "R5 idle bus", {mem_en, buf_ready}, 0);

        // R2 plain block of 4 words, CPU idle
        cyc(0, '0, 0, 0, '0, '0, 1, 16'h0200, 8'd4, 0);
        for (int k = 0; k < 4; k++) cyc(1, 32'hD000_0000 + k, 0, 0, '0, '0, 0, '0, '0, 0);
        idle(1);
        chk(irq == 1'b1 && busy == 1'b0, "R6 irq after last word", {irq, busy}, 2'b10);
        chk(blk_writes == 4, "R2 word count", 64'(blk_writes), 4);
        idle(3);
        chk(irq == 1'b1, "R7 irq holds", 64'(irq), 1);
        // R9 start while irq pending, in the same cycle as clear
        cyc(0, '0, 0, 0, '0, '0, 1, 16'h0900, 8'd2, 1);
        idle(1);
        chk(busy == 1'b0 && irq == 1'b0, "R9 start with clear ignored", {busy, irq}, 0);
        chk(irq == 1'b0, "R7 irq cleared", 64'(irq), 0);

        // R3/R11 contention with gaps in buffer valid
        cyc(0, '0, 0, 0, '0, '0, 1, 16'h0300, 8'd3, 0);
        cyc(1, 32'hC000_0000, 1, 1, 16'h0050, 32'h5555_0000, 0, '0, '0, 0);
        chk(cpu_stall == 1'b1 && mem_addr == 16'h0300, "R3 dma wins", {cpu_stall, mem_addr}, {1'b1, 16'h0300});
        cyc(0, '0, 1, 1, 16'h0050, 32'h5555_0000, 0, '0, '0, 0);
        chk(!cpu_stall && mem_addr == 16'h0050 && mem_wdata == 32'h5555_0000, "R11 retried access",
            {cpu_stall, mem_addr}, {1'b0, 16'h0050});
        cyc(1, 32'hC000_0001, 1, 0, 16'h0060, '0, 0, '0, '0, 0);
        cyc(1, 32'hC000_0002, 1, 0, 16'h0060, '0, 0, '0, '0, 0);
        cyc(0, '0, 1, 0, 16'h0060, '0, 0, '0, '0, 0);
        chk(!cpu_stall && mem_addr == 16'h0060 && irq, "R11 served after block", {cpu_stall, mem_addr}, {1'b0, 16'h0060});
        chk(blk_writes == 3, "R6 block of three", 64'(blk_writes), 3);
        cyc(0, '0, 0, 0, '0, '0, 0, '0, '0, 1);
        idle(1);

        // R10 zero-length start
        cyc(0, '0, 0, 0, '0, '0, 1, 16'h0A00, 8'd0, 0);
        idle(1);
        chk(busy == 1'b0, "R10 zero length ignored", 64'(busy), 0);

        // R8 start during a transfer, R4 valid low during transfer
        cyc(0, '0, 0, 0, '0, '0, 1, 16'h0400, 8'd5, 0);
        cyc(1, 32'hB000_0000, 0, 0, '0, '0, 0, '0, '0, 0);
        cyc(1, 32'hB000_0001, 0, 0, '0, '0, 0, '0, '0, 0);
        cyc(0, '0, 1, 1, 16'h0070, 32'h7777_0000, 1, 16'h0700, 8'd2, 0);
        chk(!buf_ready && !cpu_stall && mem_addr == 16'h0070, "R4 cpu free while no word",
            {buf_ready, cpu_stall, mem_addr}, {2'b00, 16'h0070});
        cyc(1, 32'hB000_0002, 0, 0, '0, '0, 1, 16'h0700, 8'd2, 0);
        chk(mem_addr == 16'h0402, "R8 address continues", 64'(mem_addr), 64'h402);
        cyc(1, 32'hB000_0003, 0, 0, '0, '0, 0, '0, '0, 0);
        cyc(1, 32'hB000_0004, 1, 0, 16'h0080, '0, 0, '0, '0, 0);
        idle(1);
        chk(blk_writes == 5 && irq, "R8 original count kept", 64'(blk_writes), 5);
        cyc(0, '0, 0, 0, '0, '0, 0, '0, '0, 1);

        // R6 single-word block
        cyc(0, '0, 0, 0, '0, '0, 1, 16'h0FFF, 8'd1, 0);
        cyc(1, 32'hA000_0000, 1, 1, 16'h0090, 32'h9, 0, '0, '0, 0);
        cyc(0, '0, 0, 0, '0, '0, 0, '0, '0, 0);
        chk(irq && !busy, "R6 one-word block irq", {irq, busy}, 2'b10);
        chk(blk_writes == 1, "R6 one-word count", 64'(blk_writes), 1);
        idle(2);
        chk(exp_q.size() == 0, "R2 scoreboard drained", 64'(exp_q.size()), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule